// File: doc/BRIEF.md
# Self-Clocked Serial Result Transmitter

This block is the converter side of a serial port that runs as bus master. Each time the conversion core signals that a result is ready, the block makes its own serial clock from the system clock, pulls its read-frame strobe low, and shifts out a 16-bit word. The word is a zero, then the 3-bit channel number, then the 12-bit result, each field most significant bit first. When the last bit has gone out, the block stops driving the data line.

The same clock engine also takes configuration writes. A host pulls the write-frame strobe low and presents data bits, and the block clocks them in with its own serial clock. The first five bits carry a channel number, a convert bit and a standby bit. The block decodes them into its configuration outputs and ignores the rest of the frame. One frame runs at a time. A result that arrives while a frame is running is held and sent as soon as the line is free. A pending result goes before a pending write.

All inputs are synchronous to `clk`. The SCLK half period is `half_period_m1 + 1` system clock cycles.

Top module: `selfclk_result_port`

## Requirements
- R1: During and right after synchronous reset: `ser_clk` is 1, `rd_frame_n` is 1, `ser_out_en` and `ser_out` are 0, the configuration outputs are all 0 and `convert_pulse` is 0.
- R2: A `conv_done` pulse seen at a clock edge while idle makes `rd_frame_n` go low and `ser_out_en` go high at that same edge, with the first bit (0) already on `ser_out`.
- R3: The read frame sends bit k (k = 1..16) before the k-th falling edge of `ser_clk`: bit 1 is 0, bits 2..4 are the channel bits 2,1,0, and bits 5..16 are result bits 11 down to 0. Channel and result are sampled when `conv_done` is seen.
- R4: Inside a read frame, `ser_out` changes only at a rising edge of `ser_clk` and stays stable while `ser_clk` is low.
- R5: `ser_clk` has a period of 2*(`half_period_m1`+1) system cycles during a frame and stays at 1 between frames.
- R6: `rd_frame_n` stays low for 16 full `ser_clk` cycles. At the 16th rising edge it returns to 1 and `ser_out_en` drops to 0 at the same edge.
- R7: A `conv_done` that arrives during a running frame is held. Its frame starts once the running frame ends, and it carries the channel and result sampled when it arrived.
- R8: A falling edge on `wr_frame_n` while idle starts a write frame of 16 `ser_clk` cycles, during which `rd_frame_n` stays 1 and `ser_out_en` stays 0.
- R9: In a write frame, `ser_in` is sampled at each falling edge of `ser_clk`. The first five bits give the channel (bit 2 first), then the convert bit, then the standby bit. Bits 6..16 leave the configuration outputs unchanged.
- R10: The configuration outputs change at the 5th falling edge of a write frame and not before. `convert_pulse` is high for exactly one system cycle at that moment if the convert bit is 1, and stays 0 if it is 0.
- R11: When a result and a write are both waiting while idle, the read frame runs first and the write frame runs right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| half_period_m1 | input | DIV_W | SCLK half period in system cycles, minus one |
| conv_done | input | 1 | One-cycle pulse when a conversion completes |
| chan_addr | input | 3 | Channel number to place in the read frame |
| conv_result | input | 12 | Conversion result to place in the read frame |
| wr_frame_n | input | 1 | Host write-frame strobe, active low; its falling edge requests a write |
| ser_in | input | 1 | Serial write data, sampled on SCLK falling edges |
| ser_clk | output | 1 | Generated serial clock, idles high |
| rd_frame_n | output | 1 | Read-frame strobe, low during a read frame |
| ser_out | output | 1 | Serial read data, changes on SCLK rising edges |
| ser_out_en | output | 1 | Drive enable for ser_out; low means high impedance |
| cfg_chan | output | 3 | Decoded channel field of the last write |
| cfg_convert | output | 1 | Decoded convert bit of the last write |
| cfg_standby | output | 1 | Decoded standby bit of the last write |
| convert_pulse | output | 1 | One-cycle pulse when a write with the convert bit set takes effect |

## Verification
A bit counter that is off by one shows at the ports within one frame. The strobe releases a half period early or late against the 16th SCLK rising edge, or the configuration outputs change at the 4th or 6th falling edge instead of the 5th. A lost or duplicated pending flag shows as a missing second frame or an extra one right after the current frame ends. A wrongly loaded hold register shows as wrong bits in that frame. A fault in the shift path shows up in the first wrong bit sampled on a falling edge, at most 16 SCLK cycles into the frame.

// File: rtl/scrp_pkg.sv
`timescale 1ns/1ps
package scrp_pkg;
    localparam int RES_W     = 12;
    localparam int CHAN_W    = 3;
    localparam int FRAME_W   = 1 + CHAN_W + RES_W;
    localparam int CFG_W     = CHAN_W + 2;
    localparam int BIT_CNT_W = $clog2(FRAME_W);
    localparam int CFG_CNT_W = $clog2(CFG_W + 1);

    typedef enum logic {
        XFER_READ  = 1'b0,
        XFER_WRITE = 1'b1
    } xfer_kind_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              convert;
        logic              standby;
    } cfg_t;

    typedef logic [FRAME_W-1:0] frame_t;

    // leading zero, channel, result; most significant bit goes out first
    function automatic frame_t build_frame(input logic [CHAN_W-1:0] chan,
                                           input logic [RES_W-1:0]  res);
        return {1'b0, chan, res};
    endfunction

    // first received bit is the channel MSB; the last two are convert, standby
    function automatic cfg_t decode_cfg(input logic [CFG_W-1:0] bits);
        cfg_t c;
        c.chan    = bits[CFG_W-1 -: CHAN_W];
        c.convert = bits[1];
        c.standby = bits[0];
        return c;
    endfunction
endpackage

// File: rtl/scrp_divider.sv
`timescale 1ns/1ps
module scrp_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] half_m1,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt_q <= '0;
        else if (cnt_q >= half_m1)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = en && (cnt_q >= half_m1);
endmodule

// File: rtl/scrp_framer.sv
`timescale 1ns/1ps
module scrp_framer
    import scrp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       req_rd,
    input  logic       req_wr,
    output logic       busy_o,
    output xfer_kind_e kind_o,
    output logic       sclk_o,
    output logic       fall_o,
    output logic       rise_o,
    output logic       take_o
);
    localparam logic [BIT_CNT_W-1:0] LAST_RISE = BIT_CNT_W'(FRAME_W - 1);

    logic [BIT_CNT_W-1:0] rise_cnt_q;

    assign take_o = !busy_o && (req_rd || req_wr);
    assign fall_o = busy_o && tick && sclk_o;
    assign rise_o = busy_o && tick && !sclk_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o     <= 1'b0;
            kind_o     <= XFER_READ;
            sclk_o     <= 1'b1;
            rise_cnt_q <= '0;
        end else if (take_o) begin
            busy_o     <= 1'b1;
            kind_o     <= req_rd ? XFER_READ : XFER_WRITE;
            sclk_o     <= 1'b1;
            rise_cnt_q <= '0;
        end else if (busy_o && tick) begin
            sclk_o <= !sclk_o;
            if (!sclk_o) begin
                rise_cnt_q <= rise_cnt_q + 1'b1;
                if (rise_cnt_q == LAST_RISE)
                    busy_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/scrp_cfg_capture.sv
`timescale 1ns/1ps
module scrp_cfg_capture
    import scrp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic sample,
    input  logic ser_in,
    output cfg_t cfg_o,
    output logic convert_pulse_o
);
    localparam logic [CFG_CNT_W-1:0] LAST_CFG = CFG_CNT_W'(CFG_W - 1);

    logic [CFG_W-2:0]     shift_q;
    logic [CFG_CNT_W-1:0] got_q;
    logic [CFG_W-1:0]     next_bits;
    cfg_t                 next_cfg;

    assign next_bits = {shift_q, ser_in};
    assign next_cfg  = decode_cfg(next_bits);

    always_ff @(posedge clk) begin
        convert_pulse_o <= 1'b0;
        if (rst) begin
            shift_q <= '0;
            got_q   <= '0;
            cfg_o   <= '0;
        end else if (start) begin
            got_q <= '0;
        end else if (sample && (got_q < CFG_CNT_W'(CFG_W))) begin
            shift_q <= next_bits[CFG_W-2:0];
            got_q   <= got_q + 1'b1;
            if (got_q == LAST_CFG) begin
                cfg_o           <= next_cfg;
                convert_pulse_o <= next_cfg.convert;
            end
        end
    end
endmodule

// File: rtl/selfclk_result_port.sv
`timescale 1ns/1ps
module selfclk_result_port
    import scrp_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  half_period_m1,
    input  logic              conv_done,
    input  logic [CHAN_W-1:0] chan_addr,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              wr_frame_n,
    input  logic              ser_in,
    output logic              ser_clk,
    output logic              rd_frame_n,
    output logic              ser_out,
    output logic              ser_out_en,
    output logic [CHAN_W-1:0] cfg_chan,
    output logic              cfg_convert,
    output logic              cfg_standby,
    output logic              convert_pulse
);
    logic       tick, frm_busy, fall, rise, take;
    xfer_kind_e frm_kind;
    logic       wr_frame_q, wr_fall, conv_pend_q, wr_pend_q;
    logic       rd_req, wr_req, rd_take;
    logic       rd_active, wr_active;
    frame_t     hold_q, shift_q;
    cfg_t       cfg;

    // host strobe edge detection
    always_ff @(posedge clk) begin
        if (rst) wr_frame_q <= 1'b1;
        else     wr_frame_q <= wr_frame_n;
    end
    assign wr_fall = wr_frame_q && !wr_frame_n;

    assign rd_req  = conv_done || conv_pend_q;
    assign wr_req  = wr_fall || wr_pend_q;
    assign rd_take = take && rd_req;

    scrp_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .en(frm_busy), .half_m1(half_period_m1), .tick(tick)
    );

    scrp_framer u_frm (
        .clk(clk), .rst(rst), .tick(tick), .req_rd(rd_req), .req_wr(wr_req),
        .busy_o(frm_busy), .kind_o(frm_kind), .sclk_o(ser_clk),
        .fall_o(fall), .rise_o(rise), .take_o(take)
    );

    assign rd_active = frm_busy && (frm_kind == XFER_READ);
    assign wr_active = frm_busy && (frm_kind == XFER_WRITE);

    // pending requests and the held frame
    always_ff @(posedge clk) begin
        if (rst) begin
            conv_pend_q <= 1'b0;
            wr_pend_q   <= 1'b0;
            hold_q      <= '0;
            shift_q     <= '0;
        end else begin
            if (rd_take)
                conv_pend_q <= conv_pend_q && conv_done;
            else
                conv_pend_q <= conv_pend_q || conv_done;

            if (take && !rd_req)
                wr_pend_q <= 1'b0;
            else
                wr_pend_q <= wr_pend_q || wr_fall;

            if (conv_done && !(rd_take && !conv_pend_q))
                hold_q <= build_frame(chan_addr, conv_result);

            if (rd_take)
                shift_q <= conv_pend_q ? hold_q : build_frame(chan_addr, conv_result);
            else if (rise && rd_active)
                shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
        end
    end

    scrp_cfg_capture u_cfg (
        .clk(clk), .rst(rst), .start(take && !rd_req),
        .sample(fall && wr_active), .ser_in(ser_in),
        .cfg_o(cfg), .convert_pulse_o(convert_pulse)
    );

    assign rd_frame_n  = !rd_active;
    assign ser_out_en  = rd_active;
    assign ser_out     = rd_active && shift_q[FRAME_W-1];
    assign cfg_chan    = cfg.chan;
    assign cfg_convert = cfg.convert;
    assign cfg_standby = cfg.standby;
endmodule

// File: rtl/scrp_checker.sv
`timescale 1ns/1ps
module scrp_checker
    import scrp_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic sclk,
    input logic rd_frame_n,
    input logic ser_out,
    input logic ser_out_en,
    input logic [CFG_W-1:0] cfg_bits,
    input logic convert_pulse,
    input logic busy,
    input logic wr_active
);
    AST_DOUT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (ser_out_en && $past(ser_out_en) && (ser_out != $past(ser_out))) |-> $rose(sclk)); // R4

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sclk); // R5

    AST_FRAME_END_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_frame_n) |-> ($rose(sclk) && !ser_out_en)); // R6

    AST_LEADING_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_frame_n) |-> (!ser_out && ser_out_en)); // R3

    AST_CFG_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_bits) |-> $past(wr_active)); // R9

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        convert_pulse |=> !convert_pulse); // R10

    AST_WRITE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        wr_active |-> (rd_frame_n && !ser_out_en)); // R8
endmodule

bind selfclk_result_port scrp_checker u_chk (
    .clk(clk), .rst(rst), .sclk(ser_clk), .rd_frame_n(rd_frame_n),
    .ser_out(ser_out), .ser_out_en(ser_out_en),
    .cfg_bits({cfg_chan, cfg_convert, cfg_standby}),
    .convert_pulse(convert_pulse), .busy(frm_busy), .wr_active(wr_active)
);

// File: tb/selfclk_result_port_test.sv
`timescale 1ns/1ps
module selfclk_result_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  half_period_m1 = 8'd2;
    logic        conv_done = 1'b0;
    logic [2:0]  chan_addr = '0;
    logic [11:0] conv_result = '0;
    logic        wr_frame_n = 1'b1;
    logic        ser_in = 1'b0;
    logic        ser_clk, rd_frame_n, ser_out, ser_out_en;
    logic [2:0]  cfg_chan;
    logic        cfg_convert, cfg_standby, convert_pulse;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [4:0] cfg_now = '0;   // bench model of {chan, convert, standby}

    always #2 clk = ~clk;

    selfclk_result_port uut (
        .clk(clk), .rst(rst), .half_period_m1(half_period_m1),
        .conv_done(conv_done), .chan_addr(chan_addr), .conv_result(conv_result),
        .wr_frame_n(wr_frame_n), .ser_in(ser_in),
        .ser_clk(ser_clk), .rd_frame_n(rd_frame_n), .ser_out(ser_out),
        .ser_out_en(ser_out_en), .cfg_chan(cfg_chan), .cfg_convert(cfg_convert),
        .cfg_standby(cfg_standby), .convert_pulse(convert_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // capture one read frame on SCLK falling edges
    task automatic capture(input int half, output logic [15:0] w);
        time t_first = 0;
        wait (rd_frame_n == 1'b0);
        for (int i = 0; i < 16; i++) begin
            @(negedge ser_clk);
            if (i == 0) t_first = $time;
            if (i == 1) check(($time - t_first) == time'(8 * half), "R5 period", int'($time - t_first), 8 * half);
            #1;
            w[15-i] = ser_out;
            check(rd_frame_n == 1'b0 && ser_out_en, "R6 strobe held", rd_frame_n, 0);
            #(4 * half - 2);
            check(ser_out == w[15-i], "R4 stable while low", ser_out, w[15-i]);
        end
        @(posedge ser_clk);
        #1;
        check(rd_frame_n == 1'b1 && !ser_out_en, "R6 release on 16th rise", {rd_frame_n, ser_out_en}, 2);
    endtask

    task automatic launch(input logic [2:0] ch, input logic [11:0] res);
        @(negedge clk);
        conv_done = 1'b1; chan_addr = ch; conv_result = res;
        @(posedge clk);
        #1;
        conv_done = 1'b0;
        check(rd_frame_n == 1'b0 && ser_out_en && !ser_out, "R2 frame start",
              {rd_frame_n, ser_out_en, ser_out}, 3'b010);
    endtask

    // drive write bits; w[15] must already be on ser_in before the frame starts
    task automatic wr_bits(input logic [15:0] w);
        logic [4:0] newcfg;
        newcfg = w[15:11];
        for (int i = 0; i < 16; i++) begin
            @(negedge ser_clk);
            #1;
            if (i == 0) wr_frame_n = 1'b1;
            check(rd_frame_n && !ser_out_en, "R8 no read strobe", {rd_frame_n, ser_out_en}, 2);
            if (i == 3)
                check({cfg_chan, cfg_convert, cfg_standby} == cfg_now, "R10 not before 5th bit",
                      {cfg_chan, cfg_convert, cfg_standby}, cfg_now);
            if (i == 4) begin
                check({cfg_chan, cfg_convert, cfg_standby} == newcfg, "R9 fields",
                      {cfg_chan, cfg_convert, cfg_standby}, newcfg);
                check(convert_pulse == newcfg[1], "R10 convert pulse", convert_pulse, newcfg[1]);
            end
            @(posedge ser_clk);
            #1;
            if (i < 15) ser_in = w[14-i];
        end
        check(ser_clk && rd_frame_n, "R8 frame over", {ser_clk, rd_frame_n}, 3);
        cfg_now = newcfg;
        repeat (3) @(posedge clk);
        #1;
        check({cfg_chan, cfg_convert, cfg_standby} == cfg_now, "R9 later bits ignored",
              {cfg_chan, cfg_convert, cfg_standby}, cfg_now);
    endtask

    task automatic do_write(input logic [15:0] w);
        ser_in = w[15];
        @(negedge clk);
        wr_frame_n = 1'b0;
        wr_bits(w);
    endtask

    task automatic t_reset();
        check(ser_clk == 1'b1, "R1 sclk", ser_clk, 1);
        check(rd_frame_n == 1'b1 && !ser_out_en && !ser_out, "R1 strobe/data",
              {rd_frame_n, ser_out_en, ser_out}, 3'b100);
        check({cfg_chan, cfg_convert, cfg_standby} == 5'd0 && !convert_pulse, "R1 cfg",
              {cfg_chan, cfg_convert, cfg_standby, convert_pulse}, 0);
    endtask

    task automatic t_read(input logic [7:0] div, input logic [2:0] ch, input logic [11:0] res);
        logic [15:0] got;
        half_period_m1 = div;
        launch(ch, res);
        capture(int'(div) + 1, got);
        check(got == {1'b0, ch, res}, "R3 frame content", got, {1'b0, ch, res});
        repeat (5) @(posedge clk);
        #1;
        check(ser_clk == 1'b1, "R5 idle high", ser_clk, 1);
    endtask

    task automatic t_held();
        logic [15:0] a, b;
        half_period_m1 = 8'd2;
        launch(3'd3, 12'h123);
        fork
            capture(3, a);
            begin
                repeat (40) @(negedge clk);
                conv_done = 1'b1; chan_addr = 3'd6; conv_result = 12'hFED;
                @(negedge clk);
                conv_done = 1'b0; chan_addr = 3'd1; conv_result = 12'h000;
            end
        join
        check(a == 16'h3123, "R7 first frame", a, 16'h3123);
        capture(3, b);
        check(b == {1'b0, 3'd6, 12'hFED}, "R7 held frame", b, {1'b0, 3'd6, 12'hFED});
        repeat (10) @(posedge clk);
        #1;
        check(rd_frame_n == 1'b1, "R7 no extra frame", rd_frame_n, 1);
    endtask

    task automatic t_priority();
        logic [15:0] got;
        logic [15:0] w;
        w = {3'b011, 1'b1, 1'b1, 11'b00000000000};
        half_period_m1 = 8'd1;
        ser_in = w[15];
        @(negedge clk);
        conv_done = 1'b1; chan_addr = 3'd2; conv_result = 12'h5A5; wr_frame_n = 1'b0;
        @(posedge clk);
        #1;
        conv_done = 1'b0;
        check(rd_frame_n == 1'b0, "R11 read first", rd_frame_n, 0);
        capture(2, got);
        check(got == {1'b0, 3'd2, 12'h5A5}, "R11 read content", got, {1'b0, 3'd2, 12'h5A5});
        wr_bits(w);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_read(8'd2, 3'd5, 12'hA5C);
        t_read(8'd0, 3'd7, 12'hFFF);
        t_read(8'd4, 3'd0, 12'h801);
        t_held();
        half_period_m1 = 8'd2;
        do_write({3'b101, 1'b1, 1'b0, 11'b11111111111});
        do_write({3'b010, 1'b0, 1'b1, 11'b10101010101});
        t_priority();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule